// File: doc/BRIEF.md
# Processor Exception and Interrupt Control Unit

This block is the system-control register unit beside a 32-bit processor core. It decides when the core leaves its instruction stream for the trap handler, and it holds the state that the handler needs. Two kinds of event can cause this. Synchronous exceptions arrive with a 4-bit cause code, the PC of the faulting instruction, and an optional faulting address. Asynchronous device interrupts arrive on eight request lines. A request line is first synchronised. It is then taken only when the core signals an instruction boundary, the global enable is set, and the matching mask bit is set. An interrupt therefore never cuts off an instruction part-way through.

Every taken event redirects the core, in the same cycle, to one fixed handler vector. On the next clock edge the block saves the return PC, records the cause code, and clears the global interrupt enable. The previous value of the enable is kept in a shadow bit. A return-from-exception request redirects the core to the saved PC and restores the enable from the shadow bit. Software reaches the four registers by register number through a move-to write port and a combinational move-from read port.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, Status (number 12), Cause (number 13), EPC (number 14) and BadVAddr (number 8) all read 0, and redirect_o is 0.
- R2: When exc_valid_i is high, redirect_o is high in the same cycle with redirect_pc_o = 0x80000080. After the edge, EPC holds pc_i and Cause bits 5..2 hold exc_code_i.
- R3: Taking any exception or interrupt copies Status bit 0 (global enable) into Status bit 1 and clears bit 0. A return request (eret_i) alone redirects to the EPC value in the same cycle. After the edge it copies Status bit 1 back into bit 0.
- R4: BadVAddr is loaded with badaddr_i only on an exception with badaddr_valid_i high. Otherwise it keeps its value.
- R5: Each request line appears in Cause bit 8+n through a 2-flop synchroniser: after two clock edges, but not after one.
- R6: An interrupt is taken only when boundary_i is 1, Status bit 0 is 1, and a pending line has its Status mask bit (8+n) set. It records cause code 0 and saves pc_i into EPC.
- R7: An exception in the same cycle wins over an interrupt and over a return request. Its code is recorded, and the redirect goes to the vector.
- R8: Register access is by number. Only Status bits 15..8, 1 and 0 are writable. Writes to Cause, BadVAddr and unimplemented numbers are ignored. Unimplemented numbers read 0.
- R9: A move-to write in the same cycle as a redirect event is dropped. The event's update of Status and EPC stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Asynchronous interrupt request lines |
| exc_valid_i | input | 1 | Synchronous exception raised this cycle |
| exc_code_i | input | 4 | Cause code of the exception |
| badaddr_valid_i | input | 1 | Exception carries a faulting address |
| badaddr_i | input | 32 | Faulting address |
| pc_i | input | 32 | PC of the faulting instruction or of the instruction at the boundary |
| boundary_i | input | 1 | Core is at an instruction boundary |
| eret_i | input | 1 | Return-from-exception request |
| mtc_en_i | input | 1 | Move-to register write strobe |
| mtc_sel_i | input | 5 | Move-to register number |
| mtc_data_i | input | 32 | Move-to write data |
| mfc_sel_i | input | 5 | Move-from register number |
| mfc_data_o | output | 32 | Move-from read data |
| redirect_o | output | 1 | Core must fetch from redirect_pc_o |
| redirect_pc_o | output | 32 | Handler vector or return PC |

## Verification
The assertions check four rules on every cycle:
- any redirect other than a return targets the vector;
- a taken event saves the PC and clears the enable;
- an interrupt is never taken without a boundary and a set enable, or while an exception is raised;
- BadVAddr never changes without an exception.

Some behaviours are left to the directed scenarios:
- the two-cycle visibility of a request line in Cause;
- the exact Status and Cause values after each event;
- which bits are writable, and which register numbers are ignored;
- a move-to write being dropped in a collision with an event.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN      = 32;
  localparam int SEL_W     = 5;
  localparam int CODE_W    = 4;
  localparam int IRQ_LO    = 8;
  localparam int CODE_LO   = 2;
  localparam int STAT_IE   = 0;
  localparam int STAT_PIE  = 1;

  localparam logic [SEL_W-1:0] SEL_BADVA  = 5'd8;
  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  localparam logic [CODE_W-1:0] CODE_IRQ = 4'd0;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_EXC,
    EV_IRQ,
    EV_RET
  } event_e;
endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
  parameter int IRQ_N  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] irq_i,
  output logic [IRQ_N-1:0] pend_o
);
  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else if (STAGES == 1) sh_q <= irq_i[g];
      else sh_q <= {sh_q[STAGES-2:0], irq_i[g]};
    end
    assign pend_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic             exc_valid_i,
  input  logic             eret_i,
  input  logic             boundary_i,
  input  logic             ie_i,
  input  logic [IRQ_N-1:0] pend_i,
  input  logic [IRQ_N-1:0] mask_i,
  output event_e           ev_o,
  output logic             take_irq_o
);
  logic irq_req;
  assign irq_req    = ie_i && boundary_i && |(pend_i & mask_i);
  assign take_irq_o = irq_req && !exc_valid_i;

  // exception > interrupt > return
  always_comb begin
    if (exc_valid_i)     ev_o = EV_EXC;
    else if (irq_req)    ev_o = EV_IRQ;
    else if (eret_i)     ev_o = EV_RET;
    else                 ev_o = EV_NONE;
  end
endmodule

// File: rtl/exc_regfile.sv
module exc_regfile
  import exc_ctrl_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  event_e            ev_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              badaddr_valid_i,
  input  logic [XLEN-1:0]   badaddr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IRQ_N-1:0]  pend_i,
  input  logic              mtc_en_i,
  input  logic [SEL_W-1:0]  mtc_sel_i,
  input  logic [XLEN-1:0]   mtc_data_i,
  input  logic [SEL_W-1:0]  mfc_sel_i,
  output logic [XLEN-1:0]   mfc_data_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   badva_o
);
  localparam logic [XLEN-1:0] MASK_FIELD = ((XLEN'(1) << IRQ_N) - XLEN'(1)) << IRQ_LO;
  localparam logic [XLEN-1:0] STAT_WMASK = MASK_FIELD | XLEN'(3);

  logic [XLEN-1:0]   status_q, epc_q, badva_q, cause;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      epc_q    <= '0;
      badva_q  <= '0;
      code_q   <= '0;
    end else begin
      unique case (ev_i)
        EV_EXC, EV_IRQ: begin
          status_q[STAT_PIE] <= status_q[STAT_IE];
          status_q[STAT_IE]  <= 1'b0;
          epc_q              <= pc_i;
          code_q             <= (ev_i == EV_EXC) ? exc_code_i : CODE_IRQ;
          if (ev_i == EV_EXC && badaddr_valid_i) badva_q <= badaddr_i;
        end
        EV_RET: status_q[STAT_IE] <= status_q[STAT_PIE];
        default: begin
          if (mtc_en_i) begin
            if (mtc_sel_i == SEL_STATUS) status_q <= mtc_data_i & STAT_WMASK;
            else if (mtc_sel_i == SEL_EPC) epc_q <= mtc_data_i;
          end
        end
      endcase
    end
  end

  always_comb begin
    cause = '0;
    cause[IRQ_LO +: IRQ_N]   = pend_i;
    cause[CODE_LO +: CODE_W] = code_q;
  end

  always_comb begin
    unique case (mfc_sel_i)
      SEL_STATUS: mfc_data_o = status_q;
      SEL_CAUSE:  mfc_data_o = cause;
      SEL_EPC:    mfc_data_o = epc_q;
      SEL_BADVA:  mfc_data_o = badva_q;
      default:    mfc_data_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign epc_o    = epc_q;
  assign badva_o  = badva_q;
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_ctrl_pkg::*;
#(
  parameter int              IRQ_N       = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [XLEN-1:0] VECTOR      = 32'h8000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              badaddr_valid_i,
  input  logic [XLEN-1:0]   badaddr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              boundary_i,
  input  logic              eret_i,
  input  logic              mtc_en_i,
  input  logic [SEL_W-1:0]  mtc_sel_i,
  input  logic [XLEN-1:0]   mtc_data_i,
  input  logic [SEL_W-1:0]  mfc_sel_i,
  output logic [XLEN-1:0]   mfc_data_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o
);
  logic [IRQ_N-1:0] pend;
  logic [XLEN-1:0]  status_q, epc_q, badva_q;
  event_e           ev;
  logic             take_irq;

  exc_irq_sync #(.IRQ_N(IRQ_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .pend_o (pend)
  );

  exc_arbiter #(.IRQ_N(IRQ_N)) u_arb (
    .exc_valid_i (exc_valid_i),
    .eret_i      (eret_i),
    .boundary_i  (boundary_i),
    .ie_i        (status_q[STAT_IE]),
    .pend_i      (pend),
    .mask_i      (status_q[IRQ_LO +: IRQ_N]),
    .ev_o        (ev),
    .take_irq_o  (take_irq)
  );

  exc_regfile #(.IRQ_N(IRQ_N)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ev_i            (ev),
    .exc_code_i      (exc_code_i),
    .badaddr_valid_i (badaddr_valid_i),
    .badaddr_i       (badaddr_i),
    .pc_i            (pc_i),
    .pend_i          (pend),
    .mtc_en_i        (mtc_en_i),
    .mtc_sel_i       (mtc_sel_i),
    .mtc_data_i      (mtc_data_i),
    .mfc_sel_i       (mfc_sel_i),
    .mfc_data_o      (mfc_data_o),
    .status_o        (status_q),
    .epc_o           (epc_q),
    .badva_o         (badva_q)
  );

  assign redirect_o    = (ev != EV_NONE);
  assign redirect_pc_o = (ev == EV_RET) ? epc_q : VECTOR;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_ctrl_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0080
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_valid_i,
  input logic            eret_i,
  input logic            boundary_i,
  input logic [XLEN-1:0] pc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            take_irq,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] badva_q
);
  p_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i || take_irq) |-> (redirect_o && redirect_pc_o == VECTOR));

  p_epc_save_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i || take_irq) |=> (epc_q == $past(pc_i)));

  p_ie_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i || take_irq) |=> (!status_q[STAT_IE] && status_q[STAT_PIE] == $past(status_q[STAT_IE])));

  p_ret_restore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_valid_i && !take_irq) |=> (status_q[STAT_IE] == $past(status_q[STAT_PIE])));

  p_badva_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_i |=> $stable(badva_q));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq |-> (boundary_i && status_q[STAT_IE]));

  p_exc_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> !take_irq);
endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.VECTOR(VECTOR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exc_valid_i   (exc_valid_i),
  .eret_i        (eret_i),
  .boundary_i    (boundary_i),
  .pc_i          (pc_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .take_irq      (take_irq),
  .status_q      (status_q),
  .epc_q         (epc_q),
  .badva_q       (badva_q)
);

// File: tb/exc_ctrl_unit_test.sv
`timescale 1ns/1ps
module exc_ctrl_unit_test;
  localparam logic [31:0] VEC = 32'h8000_0080;
  localparam logic [4:0] R_BADVA = 5'd8, R_STAT = 5'd12, R_CAUSE = 5'd13, R_EPC = 5'd14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [3:0]  exc_code_i = '0;
  logic        badaddr_valid_i = 1'b0;
  logic [31:0] badaddr_i = '0;
  logic [31:0] pc_i = '0;
  logic        boundary_i = 1'b0;
  logic        eret_i = 1'b0;
  logic        mtc_en_i = 1'b0;
  logic [4:0]  mtc_sel_i = '0;
  logic [31:0] mtc_data_i = '0;
  logic [4:0]  mfc_sel_i = '0;
  logic [31:0] mfc_data_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .badaddr_valid_i(badaddr_valid_i), .badaddr_i(badaddr_i),
    .pc_i(pc_i), .boundary_i(boundary_i), .eret_i(eret_i),
    .mtc_en_i(mtc_en_i), .mtc_sel_i(mtc_sel_i), .mtc_data_i(mtc_data_i),
    .mfc_sel_i(mfc_sel_i), .mfc_data_o(mfc_data_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] sel, output logic [31:0] v);
    mfc_sel_i = sel;
    #0.5;
    v = mfc_data_o;
  endtask

  task automatic chk_reg(string req, logic [4:0] sel, logic [31:0] exp);
    logic [31:0] v;
    rd(sel, v);
    check(req, v, exp);
  endtask

  task automatic wr(logic [4:0] sel, logic [31:0] d);
    @(negedge clk);
    mtc_en_i = 1'b1; mtc_sel_i = sel; mtc_data_i = d;
    @(negedge clk);
    mtc_en_i = 1'b0;
  endtask

  task automatic clear_ev();
    exc_valid_i = 1'b0; badaddr_valid_i = 1'b0; boundary_i = 1'b0;
    eret_i = 1'b0; mtc_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_reg("R1 status", R_STAT, 32'h0);
    chk_reg("R1 cause", R_CAUSE, 32'h0);
    chk_reg("R1 epc", R_EPC, 32'h0);
    chk_reg("R1 badva", R_BADVA, 32'h0);
    check("R1 redirect", {31'b0, redirect_o}, 32'h0);
  endtask

  task automatic t_regs();
    wr(R_STAT, 32'hFFFF_FFFF);
    chk_reg("R8 status writable bits", R_STAT, 32'h0000_FF03);
    wr(R_CAUSE, 32'hFFFF_FFFF);
    chk_reg("R8 cause read-only", R_CAUSE, 32'h0);
    wr(R_BADVA, 32'h5555_AAAA);
    chk_reg("R8 badva read-only", R_BADVA, 32'h0);
    wr(R_EPC, 32'h0000_1234);
    chk_reg("R8 epc writable", R_EPC, 32'h0000_1234);
    wr(5'd3, 32'hFFFF_FFFF);
    chk_reg("R8 unimplemented reads zero", 5'd3, 32'h0);
  endtask

  task automatic t_exception();
    wr(R_STAT, 32'h1);
    @(negedge clk);
    exc_valid_i = 1'b1; exc_code_i = 4'd5; pc_i = 32'h0040_0100;
    badaddr_valid_i = 1'b1; badaddr_i = 32'hDEAD_0003;
    #0.5;
    check("R2 redirect", {31'b0, redirect_o}, 32'h1);
    check("R2 vector", redirect_pc_o, VEC);
    @(negedge clk);
    clear_ev();
    chk_reg("R2 epc", R_EPC, 32'h0040_0100);
    chk_reg("R2 cause code", R_CAUSE, 32'h0000_0014);
    chk_reg("R3 status ie cleared, old kept", R_STAT, 32'h0000_0002);
    chk_reg("R4 badva loaded", R_BADVA, 32'hDEAD_0003);
  endtask

  task automatic t_eret();
    @(negedge clk);
    eret_i = 1'b1;
    #0.5;
    check("R3 eret redirect", {31'b0, redirect_o}, 32'h1);
    check("R3 eret target", redirect_pc_o, 32'h0040_0100);
    @(negedge clk);
    clear_ev();
    chk_reg("R3 ie restored", R_STAT, 32'h0000_0003);
  endtask

  task automatic t_no_badaddr();
    @(negedge clk);
    exc_valid_i = 1'b1; exc_code_i = 4'd10; pc_i = 32'h0040_0200;
    badaddr_valid_i = 1'b0; badaddr_i = 32'h1111_1111;
    @(negedge clk);
    clear_ev();
    chk_reg("R4 badva kept", R_BADVA, 32'hDEAD_0003);
    chk_reg("R2 cause code 10", R_CAUSE, 32'h0000_0028);
  endtask

  task automatic t_pending();
    @(negedge clk);
    irq_i = 8'h04;
    @(negedge clk);
    chk_reg("R5 not yet visible", R_CAUSE, 32'h0000_0028);
    @(negedge clk);
    chk_reg("R5 pending visible", R_CAUSE, 32'h0000_0428);
  endtask

  task automatic t_irq();
    wr(R_STAT, 32'h0000_0001);
    @(negedge clk);
    boundary_i = 1'b1; pc_i = 32'h0040_0300;
    #0.5;
    check("R6 masked line not taken", {31'b0, redirect_o}, 32'h0);
    @(negedge clk);
    clear_ev();
    wr(R_STAT, 32'h0000_0401);
    #0.5;
    check("R6 no boundary no take", {31'b0, redirect_o}, 32'h0);
    wr(R_STAT, 32'h0000_0400);
    @(negedge clk);
    boundary_i = 1'b1;
    #0.5;
    check("R6 ie off no take", {31'b0, redirect_o}, 32'h0);
    @(negedge clk);
    clear_ev();
    wr(R_STAT, 32'h0000_0401);
    @(negedge clk);
    boundary_i = 1'b1;
    #0.5;
    check("R6 irq redirect", {31'b0, redirect_o}, 32'h1);
    check("R6 irq vector", redirect_pc_o, VEC);
    @(negedge clk);
    clear_ev();
    chk_reg("R6 irq code 0", R_CAUSE, 32'h0000_0400);
    chk_reg("R6 irq epc", R_EPC, 32'h0040_0300);
    chk_reg("R3 irq status", R_STAT, 32'h0000_0402);
  endtask

  task automatic t_priority();
    wr(R_STAT, 32'h0000_0401);
    @(negedge clk);
    boundary_i = 1'b1; exc_valid_i = 1'b1; exc_code_i = 4'd12; pc_i = 32'h0040_0400;
    @(negedge clk);
    clear_ev();
    chk_reg("R7 exception over irq", R_CAUSE, 32'h0000_0430);
    chk_reg("R7 epc", R_EPC, 32'h0040_0400);
    @(negedge clk);
    exc_valid_i = 1'b1; eret_i = 1'b1; exc_code_i = 4'd4; pc_i = 32'h0040_0500;
    #0.5;
    check("R7 exception over eret", redirect_pc_o, VEC);
    @(negedge clk);
    clear_ev();
    chk_reg("R7 epc after exc+eret", R_EPC, 32'h0040_0500);
  endtask

  task automatic t_collision();
    wr(R_STAT, 32'h0000_0001);
    @(negedge clk);
    exc_valid_i = 1'b1; exc_code_i = 4'd6; pc_i = 32'h0040_0600;
    mtc_en_i = 1'b1; mtc_sel_i = R_STAT; mtc_data_i = 32'h0000_FF01;
    @(negedge clk);
    clear_ev();
    chk_reg("R9 status write dropped", R_STAT, 32'h0000_0002);
    @(negedge clk);
    exc_valid_i = 1'b1; exc_code_i = 4'd7; pc_i = 32'h0040_0700;
    mtc_en_i = 1'b1; mtc_sel_i = R_EPC; mtc_data_i = 32'h0000_ABCD;
    @(negedge clk);
    clear_ev();
    chk_reg("R9 epc write dropped", R_EPC, 32'h0040_0700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_exception();
    t_eret();
    t_no_badaddr();
    t_pending();
    t_irq();
    t_priority();
    t_collision();
    irq_i = '0;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule